// File: doc/BRIEF.md
# Four-way set-associative cache read path

This block is the lookup side of a compact instruction/data cache with four ways per set. A read request carries a 32-bit address and an access size. The address is split into a tag, a set index and a byte offset. The indexed set's four stored tags are compared at the same time against the request tag. A matching way returns a byte, halfword or longword taken from its line, zero-extended in big-endian order. When no way matches, the block reports a miss instead.

The lookup is one pipeline stage and the result register is the next. A request made in one cycle is answered in the following cycle. A new request may be issued every cycle with no wait states.

A fill port loads a tag, a valid bit and a whole line into one chosen way and set in a single cycle. A single-cycle invalidate input clears every valid bit. Refill sequencing, replacement choice and write handling belong to the surrounding logic.

Top module: `cache4w_rd`

## Requirements
- R1: The address fields are offset = bits [3:0], set index = bits [9:4] and tag = bits [31:10]. A line filled at set s with tag t hits only for addresses whose index equals s and whose tag equals t.
- R2: All four ways of one set are compared in parallel. Lines filled into each of the four ways of the same set, each with a distinct tag, all hit and return their own data.
- R3: Every response asserts exactly one of rsp_hit, rsp_miss and rsp_err.
- R4: A way whose valid bit is 0 never matches, whatever tag it holds. An invalidate pulse clears every valid bit. If an invalidate and a fill happen in the same cycle, the invalidate wins and the filled way is left invalid.
- R5: The response to a request made in cycle N appears in cycle N+1 with rsp_valid = 1. In any cycle that follows a cycle with no request, rsp_valid, rsp_hit, rsp_miss, rsp_err and rsp_data are all 0.
- R6: Requests made in consecutive cycles are each answered in the cycle after they are made, with no stall.
- R7: Size code 00 selects a byte. Byte o of a line is line bits [127-8o -: 8]. A byte read returns that byte in rsp_data[7:0] with the upper 24 bits zero.
- R8: Size code 01 selects a halfword, returned as {byte o, byte o+1} in rsp_data[15:0] with the upper bits zero. Size code 10 selects a longword, returned as {byte o, o+1, o+2, o+3}.
- R9: The error flag is raised for a halfword at an odd offset, for a longword at an offset that is not a multiple of 4, and for size code 11. An error response has rsp_err = 1, rsp_hit = 0 and rsp_data = 0, even when the tag matches.
- R10: If several valid ways in a set hold the request tag, the data comes from the lowest-numbered of them.
- R11: A fill takes effect at the clock edge that ends its cycle. A read of the same set in that same cycle sees the old contents. A read in the next cycle sees the new contents.
- R12: A miss response returns rsp_data = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the valid bits and the response register |
| rd_req | input | 1 | Read request in the address phase |
| rd_addr | input | 32 | Read address |
| rd_size | input | 2 | Access size: 00 byte, 01 halfword, 10 longword, 11 reserved |
| fill_en | input | 1 | Write one way of one set this cycle |
| fill_way | input | 2 | Way to write |
| fill_set | input | 6 | Set to write |
| fill_tag | input | 22 | Tag to store |
| fill_valid | input | 1 | Valid bit to store |
| fill_line | input | 128 | Line data; byte 0 is bits [127:120] |
| inval_all | input | 1 | Clear all valid bits |
| rsp_valid | output | 1 | A response is present this cycle |
| rsp_hit | output | 1 | The request hit |
| rsp_miss | output | 1 | The request missed |
| rsp_err | output | 1 | The request was misaligned or used the reserved size |
| rsp_data | output | 32 | Extracted, zero-extended read data |

## Verification
The properties assume that rst_n is held low until the clock is running. They also assume that rd_size carries only the four listed codes and that no input is ever X. The invalidate property assumes that a read issued straight after an invalidate sees every set empty. That holds because a fill in that same cycle only lands at its closing edge. The bench meets these conditions by driving every input on the falling edge from known values, and by releasing reset only after several clock cycles. It deliberately creates duplicate tags in a set, to check the lowest-way rule.

// File: rtl/cache4w_pkg.sv
package cache4w_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;
endpackage

// File: rtl/cache4w_way.sv
module cache4w_way #(
   parameter int SETS   = 64,
   parameter int IDX_W  = 6,
   parameter int TAG_W  = 22,
   parameter int LINE_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_set,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic              wr_valid,
   input  logic [LINE_W-1:0] wr_line,
   input  logic              clr_all,
   input  logic [IDX_W-1:0]  rd_set,
   output logic [TAG_W-1:0]  rd_tag,
   output logic              rd_valid,
   output logic [LINE_W-1:0] rd_line
);
   logic [TAG_W-1:0]  tag_mem  [SETS];
   logic [LINE_W-1:0] line_mem [SETS];
   logic [SETS-1:0]   vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vld_q <= '0;
      else if (clr_all) vld_q <= '0;
      else if (wr_en)   vld_q[wr_set] <= wr_valid;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_mem[wr_set]  <= wr_tag;
         line_mem[wr_set] <= wr_line;
      end
   end

   assign rd_tag   = tag_mem[rd_set];
   assign rd_valid = vld_q[rd_set];
   assign rd_line  = line_mem[rd_set];

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (vld_q == '0)); // R4
endmodule

// File: rtl/cache4w_match.sv
module cache4w_match #(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2,
   parameter int TAG_W = 22
) (
   input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
   input  logic [WAYS-1:0]            way_vld,
   input  logic [TAG_W-1:0]           key,
   output logic                       any_hit,
   output logic [WAY_W-1:0]           sel_way
);
   logic [WAYS-1:0] hit_vec;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = way_vld[w] && (way_tag[w] == key);
   end

   always_comb begin
      any_hit = |hit_vec;
      sel_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (hit_vec[w]) sel_way = WAY_W'(w);
      end
   end
endmodule

// File: rtl/cache4w_extract.sv
module cache4w_extract
   import cache4w_pkg::*;
#(
   parameter int LINE_BYTES = 16,
   parameter int OFF_W      = 4,
   parameter int DATA_W     = 32
) (
   input  logic [LINE_BYTES*8-1:0] line,
   input  logic [OFF_W-1:0]        off,
   input  logic [1:0]              size,
   output logic [DATA_W-1:0]       data,
   output logic                    misalign
);
   localparam int LINE_W = LINE_BYTES * 8;
   localparam int WB     = DATA_W / 8;

   logic [7:0]       bytes [LINE_BYTES];
   logic [OFF_W-1:0] mask;
   logic [OFF_W-1:0] pos;
   int               nb;

   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
      assign bytes[b] = line[LINE_W-1-8*b -: 8];
   end

   always_comb begin
      case (acc_size_e'(size))
         SZ_BYTE: nb = 1;
         SZ_HALF: nb = WB / 2;
         default: nb = WB;
      endcase
      mask     = OFF_W'(nb - 1);
      misalign = (size == SZ_RSVD) || ((off & mask) != '0);
      data     = '0;
      pos      = off;
      for (int k = 0; k < WB; k++) begin
         pos = off + OFF_W'(k);
         if (k < nb) data = {data[DATA_W-9:0], bytes[pos]};
      end
   end
endmodule

// File: rtl/cache4w_rd.sv
module cache4w_rd
   import cache4w_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SETS       = 64,
   parameter int WAYS       = 4,
   parameter int LINE_BYTES = 16,
   parameter int DATA_W     = 32,
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int IDX_W  = $clog2(SETS),
   localparam int WAY_W  = $clog2(WAYS),
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
   localparam int LINE_W = LINE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [1:0]        rd_size,
   input  logic              fill_en,
   input  logic [WAY_W-1:0]  fill_way,
   input  logic [IDX_W-1:0]  fill_set,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic              fill_valid,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              inval_all,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_data
);
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("cache4w_rd: WAYS must be a power of two of at least 2");
   end
   if ((SETS & (SETS - 1)) != 0 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_geom
      $error("cache4w_rd: SETS and LINE_BYTES must be powers of two");
   end
   if (DATA_W % 16 != 0 || LINE_BYTES < DATA_W / 8) begin : g_bad_data
      $error("cache4w_rd: DATA_W must be a multiple of 16 and fit in a line");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("cache4w_rd: address too narrow for the geometry");
   end

   // address phase
   logic [IDX_W-1:0] a_idx;
   logic [TAG_W-1:0] a_tag;
   logic [OFF_W-1:0] a_off;
   assign a_off = rd_addr[OFF_W-1:0];
   assign a_idx = rd_addr[OFF_W +: IDX_W];
   assign a_tag = rd_addr[ADDR_W-1 -: TAG_W];

   logic [WAYS-1:0][TAG_W-1:0]  w_tag;
   logic [WAYS-1:0]             w_vld;
   logic [WAYS-1:0][LINE_W-1:0] w_line;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      cache4w_way #(
         .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
      ) u_way (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (fill_en && (fill_way == WAY_W'(w))),
         .wr_set   (fill_set),
         .wr_tag   (fill_tag),
         .wr_valid (fill_valid),
         .wr_line  (fill_line),
         .clr_all  (inval_all),
         .rd_set   (a_idx),
         .rd_tag   (w_tag[w]),
         .rd_valid (w_vld[w]),
         .rd_line  (w_line[w])
      );
   end

   logic             any_hit;
   logic [WAY_W-1:0] sel_way;

   cache4w_match #(.WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_match (
      .way_tag (w_tag),
      .way_vld (w_vld),
      .key     (a_tag),
      .any_hit (any_hit),
      .sel_way (sel_way)
   );

   logic [DATA_W-1:0] x_data;
   logic              x_err;

   cache4w_extract #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_extract (
      .line     (w_line[sel_way]),
      .off      (a_off),
      .size     (rd_size),
      .data     (x_data),
      .misalign (x_err)
   );

   // data phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= rd_req;
         rsp_err   <= rd_req && x_err;
         rsp_hit   <= rd_req && !x_err && any_hit;
         rsp_miss  <= rd_req && !x_err && !any_hit;
         rsp_data  <= (rd_req && !x_err && any_hit) ? x_data : '0;
      end
   end

   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rsp_valid); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> (!rsp_valid && !rsp_hit && !rsp_miss && !rsp_err && rsp_data == '0)); // R5
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_err}) == 1)); // R3
   AST_ODD_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_size == SZ_HALF && rd_addr[0]) |=> (rsp_err && !rsp_hit && rsp_data == '0)); // R9
   AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_size == SZ_BYTE) |=> (rsp_data[DATA_W-1:8] == '0)); // R7
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_data == '0)); // R12
   AST_AFTER_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
      inval_all ##1 rd_req |=> !rsp_hit); // R4
endmodule

// File: tb/tb_cache4w_rd.sv
`timescale 1ns/1ps
module tb_cache4w_rd;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         rd_req = 1'b0;
   logic [31:0]  rd_addr = '0;
   logic [1:0]   rd_size = '0;
   logic         fill_en = 1'b0;
   logic [1:0]   fill_way = '0;
   logic [5:0]   fill_set = '0;
   logic [21:0]  fill_tag = '0;
   logic         fill_valid = 1'b0;
   logic [127:0] fill_line = '0;
   logic         inval_all = 1'b0;
   logic         rsp_valid, rsp_hit, rsp_miss, rsp_err;
   logic [31:0]  rsp_data;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   cache4w_rd dut (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
      .fill_en(fill_en), .fill_way(fill_way), .fill_set(fill_set), .fill_tag(fill_tag),
      .fill_valid(fill_valid), .fill_line(fill_line), .inval_all(inval_all),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_err(rsp_err),
      .rsp_data(rsp_data)
   );

   function automatic logic [127:0] mk_line(input logic [3:0] seed);
      logic [127:0] l;
      for (int b = 0; b < 16; b++) l[127-8*b -: 8] = {seed, 4'(b)};
      return l;
   endfunction

   function automatic logic [31:0] mk_addr(input logic [21:0] t, input logic [5:0] s, input logic [3:0] o);
      return {t, s, o};
   endfunction

   function automatic logic [31:0] pick(input logic [127:0] l, input int o, input int sz);
      logic [31:0] d;
      int n;
      n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      d = '0;
      for (int k = 0; k < n; k++) d = {d[23:0], l[127-8*((o+k)%16) -: 8]};
      return d;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic fill(input int w, input int s, input logic [21:0] t, input bit v, input logic [127:0] l);
      fill_en = 1'b1; fill_way = 2'(w); fill_set = 6'(s);
      fill_tag = t; fill_valid = v; fill_line = l;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   // drive at a falling edge, sample at the next falling edge (one register stage)
   task automatic rd(input logic [31:0] a, input int sz, input logic [2:0] exp_hme,
                     input logic [31:0] exp_d, input string req);
      rd_req = 1'b1; rd_addr = a; rd_size = 2'(sz);
      @(negedge clk);
      rd_req = 1'b0;
      chk(rsp_valid == 1'b1, req, 64'(rsp_valid), 64'd1);
      chk({rsp_hit, rsp_miss, rsp_err} == exp_hme, req, 64'({rsp_hit, rsp_miss, rsp_err}), 64'(exp_hme));
      chk(rsp_data == exp_d, req, 64'(rsp_data), 64'(exp_d));
   endtask

   task automatic t_reset();
      chk(rsp_valid == 1'b0 && rsp_data == '0, "R5 reset", 64'({rsp_valid, rsp_data}), 64'd0);
      rd(mk_addr(22'h0, 6'd0, 4'd0), 2, 3'b010, 32'h0, "R4 empty after reset");
      @(negedge clk);
      chk(!rsp_valid && !rsp_hit && !rsp_miss && !rsp_err, "R5 idle", 64'({rsp_valid, rsp_hit, rsp_miss, rsp_err}), 64'd0);
   endtask

   task automatic t_four_ways();
      for (int w = 0; w < 4; w++) fill(w, 5, 22'h100 + 22'(w), 1'b1, mk_line(4'(w + 1)));
      for (int w = 0; w < 4; w++)
         rd(mk_addr(22'h100 + 22'(w), 6'd5, 4'd0), 2, 3'b100, pick(mk_line(4'(w + 1)), 0, 2), "R2 way hit");
      rd(mk_addr(22'h100, 6'd6, 4'd0), 2, 3'b010, 32'h0, "R1 wrong set misses");
      rd(mk_addr(22'h104, 6'd5, 4'd0), 2, 3'b010, 32'h0, "R12 wrong tag misses");
      rd(mk_addr(22'h100, 6'd5, 4'd12), 2, 3'b100, pick(mk_line(4'd1), 12, 2), "R1 offset field");
   endtask

   task automatic t_sizes();
      fill(2, 33, 22'h3ABCD, 1'b1, mk_line(4'd9));
      for (int o = 0; o < 16; o += 5)
         rd(mk_addr(22'h3ABCD, 6'd33, 4'(o)), 0, 3'b100, pick(mk_line(4'd9), o, 0), "R7 byte");
      rd(mk_addr(22'h3ABCD, 6'd33, 4'd14), 1, 3'b100, pick(mk_line(4'd9), 14, 1), "R8 half");
      rd(mk_addr(22'h3ABCD, 6'd33, 4'd2), 1, 3'b100, pick(mk_line(4'd9), 2, 1), "R8 half low");
      rd(mk_addr(22'h3ABCD, 6'd33, 4'd8), 2, 3'b100, 32'h98999A9B, "R8 word big-endian");
   endtask

   task automatic t_misalign();
      rd(mk_addr(22'h3ABCD, 6'd33, 4'd3), 1, 3'b001, 32'h0, "R9 odd half");
      rd(mk_addr(22'h3ABCD, 6'd33, 4'd6), 2, 3'b001, 32'h0, "R9 word offset 6");
      rd(mk_addr(22'h3ABCD, 6'd33, 4'd1), 2, 3'b001, 32'h0, "R9 word offset 1");
      rd(mk_addr(22'h3ABCD, 6'd33, 4'd0), 3, 3'b001, 32'h0, "R9 reserved size");
   endtask

   task automatic t_invalid_way();
      fill(1, 40, 22'h55, 1'b0, mk_line(4'd3));
      rd(mk_addr(22'h55, 6'd40, 4'd0), 2, 3'b010, 32'h0, "R4 invalid way");
   endtask

   task automatic t_multi();
      fill(3, 9, 22'h77, 1'b1, mk_line(4'd12));
      fill(1, 9, 22'h77, 1'b1, mk_line(4'd7));
      rd(mk_addr(22'h77, 6'd9, 4'd4), 2, 3'b100, pick(mk_line(4'd7), 4, 2), "R10 lowest of 1,3");
      fill(0, 9, 22'h77, 1'b1, mk_line(4'd14));
      rd(mk_addr(22'h77, 6'd9, 4'd4), 2, 3'b100, pick(mk_line(4'd14), 4, 2), "R10 way 0 wins");
   endtask

   task automatic t_b2b();
      for (int w = 0; w < 4; w++) begin
         rd_req = 1'b1; rd_addr = mk_addr(22'h100 + 22'(w), 6'd5, 4'(4 * w)); rd_size = 2'd2;
         @(negedge clk);
         chk(rsp_valid && rsp_hit && rsp_data == pick(mk_line(4'(w + 1)), 4 * w, 2),
             "R6 back-to-back", 64'(rsp_data), 64'(pick(mk_line(4'(w + 1)), 4 * w, 2)));
      end
      rd_req = 1'b0;
      @(negedge clk);
      chk(!rsp_valid && rsp_data == '0, "R5 after burst", 64'({rsp_valid, rsp_data}), 64'd0);
   endtask

   task automatic t_collide();
      fill_en = 1'b1; fill_way = 2'd2; fill_set = 6'd33; fill_tag = 22'h3ABCD;
      fill_valid = 1'b1; fill_line = mk_line(4'd5);
      rd_req = 1'b1; rd_addr = mk_addr(22'h3ABCD, 6'd33, 4'd0); rd_size = 2'd2;
      @(negedge clk);
      fill_en = 1'b0;
      chk(rsp_hit && rsp_data == pick(mk_line(4'd9), 0, 2), "R11 same-cycle old data",
          64'(rsp_data), 64'(pick(mk_line(4'd9), 0, 2)));
      @(negedge clk);
      rd_req = 1'b0;
      chk(rsp_hit && rsp_data == pick(mk_line(4'd5), 0, 2), "R11 next-cycle new data",
          64'(rsp_data), 64'(pick(mk_line(4'd5), 0, 2)));
   endtask

   task automatic t_inval();
      inval_all = 1'b1;
      @(negedge clk);
      inval_all = 1'b0;
      rd(mk_addr(22'h100, 6'd5, 4'd0), 2, 3'b010, 32'h0, "R4 after invalidate");
      rd(mk_addr(22'h3ABCD, 6'd33, 4'd0), 2, 3'b010, 32'h0, "R4 after invalidate other set");
      inval_all = 1'b1;
      fill(0, 12, 22'h99, 1'b1, mk_line(4'd2));
      inval_all = 1'b0;
      rd(mk_addr(22'h99, 6'd12, 4'd0), 2, 3'b010, 32'h0, "R4 invalidate beats fill");
   endtask

   initial begin
      #(4 * 100000);
      bad++; total++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_four_ways();
      t_sizes();
      t_misalign();
      t_invalid_way();
      t_multi();
      t_b2b();
      t_collide();
      t_inval();
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule